// File: doc/BRIEF.md
# SPI Byte Master with Register Interface

This block is a single-chip-select SPI master that is controlled entirely through a small 32-bit register bus. Software sets the serial clock rate with a two-stage divider: a coarse prescale of 16 or 128, followed by a 5-bit count that divides by twice (count + 1). It also chooses the clock polarity and phase. The chip-select line is driven straight from a register bit, so software decides exactly when it is asserted and released.

A byte exchange starts when software writes the transmit register. The engine then shifts eight bits out on MOSI, most significant bit first, and shifts eight bits in from MISO at the same time. When the byte is done, the received value sits in the receive register and a status flag marks it as ready. Between transfers the serial clock rests at its polarity level and produces no edges.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, every register reads 0, `spi_cs_n` is 1 and `spi_sck` is 0.
- R2: The words written at offsets 0x00 (control), 0x08 (system control) and 0x14 (auxiliary control) read back unchanged in all 32 bits. Control bits above 7 do not change a transfer.
- R3: The SCK half period is P*(C+1) clock cycles. P is 128 when control bit 5 is 1 and 16 when it is 0, and C is control bits [4:0]. One byte takes 16 half periods and makes exactly 16 SCK edges.
- R4: Control bit 6 is CPOL and control bit 7 is CPHA. With CPHA=0 the data is sampled on the leading edge and changed on the trailing edge. With CPHA=1 the data is changed on the leading edge and sampled on the trailing edge. Bits go most significant first in both directions.
- R5: A write to offset 0x0C while idle starts an exchange of data bits [7:0]. Status bit 0 (at 0x04) reads 1 from the cycle after that write until 16 half periods have elapsed, and then reads 0.
- R6: When an exchange ends, status bit 2 is set, and offset 0x10 reads the received byte in bits [7:0] with zeros above it.
- R7: A read of offset 0x10 (`bus_re` high) clears status bit 2 in the next cycle.
- R8: A write of the value 0 to offset 0x04 clears status bit 2. The receive data is kept.
- R9: A write to offset 0x0C while status bit 0 is 1 is ignored. The running exchange keeps its byte and its length, and no second exchange follows.
- R10: `spi_cs_n` takes the value of system-control bit 6 in the cycle after each write to 0x08 and otherwise holds its value. Writing 0x21 therefore drives it low.
- R11: While no exchange is running, `spi_sck` equals CPOL and makes no edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe; clears the receive flag on a receive-data read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low, software driven |

## Verification
Register reads are combinational, so the bench samples `bus_rdata` one time unit after it sets the address, in the middle of the low clock phase. Writes, the receive-flag clear and the chip-select update all take effect at the first rising edge after the strobe. The bench checks them at the next falling edge. The busy flag is polled once per cycle, starting right after the transmit write. It must first read 0 exactly 16*P*(C+1) cycles after that write's edge, and in that same cycle the receive flag must be set. A slave model in the bench counts every SCK edge and captures MOSI on the sampling edge for the mode under test, so the edge count and the bit order are compared once the busy flag drops.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int BYTE_W = 8;
    localparam int EDGES  = 2 * BYTE_W;
    localparam int EDGE_W = $clog2(EDGES);

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_STAT  = 8'h04;
    localparam logic [7:0] OFS_SYS   = 8'h08;
    localparam logic [7:0] OFS_TXD   = 8'h0C;
    localparam logic [7:0] OFS_RXD   = 8'h10;
    localparam logic [7:0] OFS_CTRL2 = 8'h14;

    localparam int CTL_CPHA = 7;
    localparam int CTL_CPOL = 6;
    localparam int CTL_PRE  = 5;
    localparam int SYS_CS   = 6;
    localparam int ST_BUSY  = 0;
    localparam int ST_RXF   = 2;

    typedef struct packed {
        logic [31:0]       ctrl;
        logic [31:0]       sys;
        logic [31:0]       ctrl2;
        logic              cs_n;
        logic              rx_full;
        logic [BYTE_W-1:0] rx_byte;
    } regs_t;

    typedef struct packed {
        logic              busy;
        logic              phase;
        logic [EDGE_W-1:0] edge_cnt;
        logic [BYTE_W-1:0] txs;
        logic [BYTE_W-1:0] rxs;
        logic              mosi;
    } shift_t;
endpackage

// File: rtl/spim_regs.sv
module spim_regs
    import spim_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [BYTE_W-1:0] rx_in,
    output logic              cfg_cpha,
    output logic              cfg_cpol,
    output logic              cfg_pre,
    output logic [CNT_W-1:0]  cfg_cnt,
    output logic              start,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              cs_n,
    output logic              rx_full
);
    regs_t r_q, r_d;

    logic hit_ctrl, hit_stat, hit_sys, hit_txd, hit_rxd, hit_ctrl2;

    always_comb begin
        hit_ctrl  = addr == ADDR_W'(OFS_CTRL);
        hit_stat  = addr == ADDR_W'(OFS_STAT);
        hit_sys   = addr == ADDR_W'(OFS_SYS);
        hit_txd   = addr == ADDR_W'(OFS_TXD);
        hit_rxd   = addr == ADDR_W'(OFS_RXD);
        hit_ctrl2 = addr == ADDR_W'(OFS_CTRL2);

        r_d = r_q;
        if (we && hit_ctrl)  r_d.ctrl  = wdata;
        if (we && hit_ctrl2) r_d.ctrl2 = wdata;
        if (we && hit_sys) begin
            r_d.sys  = wdata;
            r_d.cs_n = wdata[SYS_CS];
        end
        if ((re && hit_rxd) || (we && hit_stat && wdata == 32'd0))
            r_d.rx_full = 1'b0;
        // completion outranks a same-cycle clear
        if (done) begin
            r_d.rx_full = 1'b1;
            r_d.rx_byte = rx_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ctrl: '0, sys: '0, ctrl2: '0, cs_n: 1'b1,
                     rx_full: 1'b0, rx_byte: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_ctrl)       rdata = r_q.ctrl;
        else if (hit_sys)   rdata = r_q.sys;
        else if (hit_ctrl2) rdata = r_q.ctrl2;
        else if (hit_rxd)   rdata[BYTE_W-1:0] = r_q.rx_byte;
        else if (hit_stat) begin
            rdata[ST_BUSY] = busy;
            rdata[ST_RXF]  = r_q.rx_full;
        end
    end

    assign start    = we && hit_txd && !busy;
    assign tx_byte  = wdata[BYTE_W-1:0];
    assign cfg_cpha = r_q.ctrl[CTL_CPHA];
    assign cfg_cpol = r_q.ctrl[CTL_CPOL];
    assign cfg_pre  = r_q.ctrl[CTL_PRE];
    assign cfg_cnt  = r_q.ctrl[CNT_W-1:0];
    assign cs_n     = r_q.cs_n;
    assign rx_full  = r_q.rx_full;
endmodule

// File: rtl/spim_baud.sv
module spim_baud #(
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 128,
    parameter int CNT_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             pre_sel,
    input  logic [CNT_W-1:0] count,
    output logic             tick
);
    localparam int HALF_MAX = PRE_HI * (1 << CNT_W);
    localparam int HW       = $clog2(HALF_MAX);

    logic [HW-1:0] cnt_q, cnt_d;
    logic [HW-1:0] lim;

    always_comb begin
        lim  = HW'((pre_sel ? PRE_HI : PRE_LO) * (int'(count) + 1) - 1);
        tick = run && !restart && (cnt_q == lim);
        if (!run || restart || tick) cnt_d = '0;
        else                         cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spim_shift.sv
module spim_shift
    import spim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tick,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              sck,
    output logic              mosi
);
    shift_t s_q, s_d;
    logic   lead, last;

    always_comb begin
        s_d  = s_q;
        lead = ~s_q.edge_cnt[0];
        last = s_q.edge_cnt == EDGE_W'(EDGES - 1);
        done = s_q.busy && tick && last;
        if (start) begin
            s_d.busy     = 1'b1;
            s_d.phase    = 1'b0;
            s_d.edge_cnt = '0;
            s_d.rxs      = '0;
            if (cpha) begin
                s_d.txs = tx_byte;
            end else begin
                s_d.mosi = tx_byte[BYTE_W-1];
                s_d.txs  = tx_byte << 1;
            end
        end else if (s_q.busy && tick) begin
            s_d.phase    = ~s_q.phase;
            s_d.edge_cnt = s_q.edge_cnt + 1'b1;
            if (lead != cpha) begin
                s_d.rxs = {s_q.rxs[BYTE_W-2:0], miso};
            end else begin
                s_d.mosi = s_q.txs[BYTE_W-1];
                s_d.txs  = s_q.txs << 1;
            end
            if (last) begin
                s_d.busy     = 1'b0;
                s_d.phase    = 1'b0;
                s_d.edge_cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // with CPHA=1 the final sample lands on the closing edge: bypass it
    assign rx_byte = cpha ? {s_q.rxs[BYTE_W-2:0], miso} : s_q.rxs;
    assign busy    = s_q.busy;
    assign sck     = cpol ^ s_q.phase;
    assign mosi    = s_q.mosi;
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spim_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 128,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    logic              cfg_cpha, cfg_cpol, cfg_pre;
    logic [CNT_W-1:0]  cfg_cnt;
    logic              xfer_start, xfer_busy, xfer_done, sck_tick, rx_full;
    logic [BYTE_W-1:0] tx_byte, rx_byte;

    spim_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .re(bus_re),
        .wdata(bus_wdata), .rdata(bus_rdata), .busy(xfer_busy), .done(xfer_done),
        .rx_in(rx_byte), .cfg_cpha(cfg_cpha), .cfg_cpol(cfg_cpol), .cfg_pre(cfg_pre),
        .cfg_cnt(cfg_cnt), .start(xfer_start), .tx_byte(tx_byte), .cs_n(spi_cs_n),
        .rx_full(rx_full)
    );

    spim_baud #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .CNT_W(CNT_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(xfer_busy), .restart(xfer_start),
        .pre_sel(cfg_pre), .count(cfg_cnt), .tick(sck_tick)
    );

    spim_shift u_shift (
        .clk(clk), .rst_n(rst_n), .start(xfer_start), .tx_byte(tx_byte),
        .tick(sck_tick), .cpol(cfg_cpol), .cpha(cfg_cpha), .miso(spi_miso),
        .busy(xfer_busy), .done(xfer_done), .rx_byte(rx_byte), .sck(spi_sck),
        .mosi(spi_mosi)
    );
endmodule

// File: rtl/spim_chk.sv
module spim_chk
    import spim_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [31:0]       bus_wdata,
    input logic              spi_sck,
    input logic              spi_cs_n,
    input logic              busy,
    input logic              done,
    input logic              rx_full,
    input logic              cpol
);
    logic wr_tx, wr_sys, wr_stat0, rd_rx;
    assign wr_tx    = bus_we && bus_addr == ADDR_W'(OFS_TXD);
    assign wr_sys   = bus_we && bus_addr == ADDR_W'(OFS_SYS);
    assign wr_stat0 = bus_we && bus_addr == ADDR_W'(OFS_STAT) && bus_wdata == 32'd0;
    assign rd_rx    = bus_re && bus_addr == ADDR_W'(OFS_RXD);

    p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && !busy) |=> busy);

    p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && busy && !done) |=> busy);

    p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (rx_full && !busy));

    p_rdclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && !done) |=> !rx_full);

    p_stclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat0 && !done) |=> !rx_full);

    p_cs_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sys |=> (spi_cs_n == $past(bus_wdata[SYS_CS])));

    p_cs_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sys |=> $stable(spi_cs_n));

    p_idle_sck_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (spi_sck == cpol));
endmodule

bind spi_byte_master spim_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .busy(xfer_busy),
    .done(xfer_done), .rx_full(rx_full), .cpol(cfg_cpol)
);

// File: tb/sim_spi_byte_master.sv
module sim_spi_byte_master;
    import spim_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 4;
    // {control byte, transmit byte, slave reply byte, spare}
    localparam logic [31:0] VEC [NV] = '{
        32'h00_A5_3C_00,
        32'h41_81_FE_00,
        32'h82_5A_01_00,
        32'hE0_FF_96_00
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sck, spi_mosi, spi_cs_n;
    logic        miso_r = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int t0 = 0;

    spi_byte_master u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(miso_r),
        .spi_cs_n(spi_cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // slave model: counts SCK edges, samples MOSI and drives MISO per mode
    logic       cpol_m = 1'b0, cpha_m = 1'b0;
    logic [7:0] sl_seed = '0, sl_tx = '0, sl_rx = '0;
    logic       sl_rst_t = 1'b0, sl_rst_seen = 1'b0;
    int         sl_edges = 0;

    always @(spi_sck or sl_rst_t) begin
        if (sl_rst_t != sl_rst_seen) begin
            sl_rst_seen = sl_rst_t;
            sl_edges = 0;
            sl_rx = '0;
            if (cpha_m) sl_tx = sl_seed;
            else begin
                miso_r = sl_seed[7];
                sl_tx  = sl_seed << 1;
            end
        end else begin
            sl_edges++;
            if ((spi_sck != cpol_m) != cpha_m) sl_rx = {sl_rx[6:0], spi_mosi};
            else begin
                miso_r = sl_tx[7];
                sl_tx  = sl_tx << 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a; bus_re = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic seed_slave(input logic [7:0] b);
        sl_seed = b;
        sl_rst_t = ~sl_rst_t;
        #1;
    endtask

    task automatic start_tx(input logic [7:0] b);
        wr(OFS_TXD, {24'hFFFFFF, b});
        t0 = cyc;
    endtask

    // polls busy once per cycle; returns cycles since the starting write edge
    task automatic wait_idle(output int n, output logic first_busy);
        bus_addr = OFS_STAT;
        #1 first_busy = bus_rdata[ST_BUSY];
        while (bus_rdata[ST_BUSY]) begin
            @(negedge clk);
            bus_addr = OFS_STAT;
            #1;
        end
        n = cyc - t0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  cb, tb, mb;
        int          half, n, e0;
        logic        fb;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(OFS_CTRL, v);  chk("R1 ctrl", v, 0);
        rd(OFS_STAT, v);  chk("R1 status", v, 0);
        rd(OFS_SYS, v);   chk("R1 sysctl", v, 0);
        rd(OFS_TXD, v);   chk("R1 txd", v, 0);
        rd(OFS_RXD, v);   chk("R1 rxd", v, 0);
        rd(OFS_CTRL2, v); chk("R1 ctrl2", v, 0);
        chk("R1 cs_n", 32'(spi_cs_n), 1);
        chk("R1 sck", 32'(spi_sck), 0);

        // R10 / R2: chip select and readback
        wr(OFS_SYS, 32'h21);
        chk("R10 cs low after 0x21", 32'(spi_cs_n), 0);
        wr(OFS_SYS, 32'hA5A5_5A40);
        chk("R10 cs high", 32'(spi_cs_n), 1);
        rd(OFS_SYS, v); chk("R2 sysctl readback", v, 32'hA5A5_5A40);
        wr(OFS_CTRL2, 32'hDEAD_BEEF);
        rd(OFS_CTRL2, v); chk("R2 ctrl2 readback", v, 32'hDEAD_BEEF);
        wr(OFS_SYS, 32'h21);
        chk("R10 cs low again", 32'(spi_cs_n), 0);

        // table-driven exchanges across the four modes and divider settings
        for (int i = 0; i < NV; i++) begin
            cb = VEC[i][31:24];
            tb = VEC[i][23:16];
            mb = VEC[i][15:8];
            half = (cb[5] ? 128 : 16) * (int'(cb[4:0]) + 1);
            cpol_m = cb[6];
            cpha_m = cb[7];
            wr(OFS_CTRL, {8'h5A, 8'(i), 8'hC3, cb});
            rd(OFS_CTRL, v); chk("R2 ctrl readback", v, {8'h5A, 8'(i), 8'hC3, cb});
            chk("R11 idle sck level", 32'(spi_sck), 32'(cb[6]));
            seed_slave(mb);
            start_tx(tb);
            wait_idle(n, fb);
            chk("R5 busy after write", 32'(fb), 1);
            chk("R3 byte duration", n, 16 * half);
            chk("R3 edge count", sl_edges, 16);
            rd(OFS_STAT, v); chk("R6 status at end", v & 32'h5, 32'h4);
            chk("R4 MOSI bits MSB first", 32'(sl_rx), 32'(tb));
            rd(OFS_RXD, v); chk("R6 receive data", v, {24'h0, mb});
            rd(OFS_STAT, v); chk("R7 flag cleared by read", v & 32'h4, 0);
            chk("R11 sck back at CPOL", 32'(spi_sck), 32'(cb[6]));
            chk("R10 cs held low", 32'(spi_cs_n), 0);
        end

        // R9: transmit write during an exchange is ignored
        cpol_m = 1'b0;
        cpha_m = 1'b0;
        wr(OFS_CTRL, 32'h0);
        seed_slave(8'h77);
        start_tx(8'h3C);
        repeat (40) @(negedge clk);
        wr(OFS_TXD, 32'hC3);
        wait_idle(n, fb);
        chk("R9 length unchanged", n, 256);
        chk("R9 edges unchanged", sl_edges, 16);
        chk("R9 original byte sent", 32'(sl_rx), 32'h3C);
        repeat (20) @(negedge clk);
        rd(OFS_STAT, v); chk("R9 no second exchange", v & 32'h5, 32'h4);

        // R8: status write of 0 clears the flag, data kept
        wr(OFS_STAT, 32'h0);
        rd(OFS_STAT, v); chk("R8 flag cleared by status write", v & 32'h4, 0);
        rd(OFS_RXD, v); chk("R8 data kept", v, 32'h77);

        // R11: no edges while idle
        e0 = sl_edges;
        repeat (200) @(negedge clk);
        chk("R11 no idle edges", sl_edges, e0);
        chk("R11 sck idle", 32'(spi_sck), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule